// File: doc/BRIEF.md
# One's-Complement Sign-Magnitude Subtractor

This block subtracts one unsigned operand from another of the same width and returns the result in sign-magnitude form. It inverts the subtrahend bit by bit and adds it to the minuend with a plain ripple adder. The carry leaving the top bit decides what happens next. A carry marks a non-negative difference: the carry is fed back into the lowest bit (end-around carry) to form the magnitude. No carry marks a negative difference: the raw sum is complemented again to give the true magnitude.

The subtraction path is purely combinational, so its outputs settle in the same cycle as the operands. An optional output register stage sits beside it, with a one-bit valid qualifier. When the valid input is high, the register captures the combinational result. When it is low, the register keeps its last contents. The operand width is a parameter.

Top module: `ocs_subtractor`

## Requirements
- R1: When A > B, `diff_neg_o` is 0 and `diff_mag_o` equals A - B. This is the end-around-carry path.
- R2: When A < B, `diff_neg_o` is 1 and `diff_mag_o` equals B - A. This is the re-complement path.
- R3: When A == B, `diff_mag_o` is 0 and `diff_neg_o` is 0. The block never outputs 1 on the sign together with a zero magnitude.
- R4: With WIDTH=5, A=5'b10000 and B=5'b11101 give `diff_neg_o`=1 and `diff_mag_o`=5'b01101.
- R5: With WIDTH=4, A=4 and B=9 give `diff_neg_o`=1 and `diff_mag_o`=5.
- R6: With WIDTH=2, the bit rules hold in the low bit with the upper bits at zero: 0-0 and 1-1 give 0, 1-0 gives 1, and each of these is positive; 0-1 gives magnitude 1 with a negative sign (the borrow).
- R7: `diff_mag_o` and `diff_neg_o` are combinational. They reflect the current operands in the same cycle, with no clock edge in between.
- R8: While `rst` is high at a rising clock edge, `out_valid_o`, `out_mag_o` and `out_neg_o` are cleared to 0.
- R9: `out_valid_o` equals the value `in_valid_i` had at the previous rising edge, outside reset.
- R10: When `in_valid_i` is high at a rising edge, `out_mag_o` and `out_neg_o` take that cycle's combinational result. When it is low, they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst | input | 1 | Synchronous active-high reset of the register stage |
| in_valid_i | input | 1 | Qualifies the operands for capture into the register stage |
| a_i | input | WIDTH | Minuend |
| b_i | input | WIDTH | Subtrahend |
| diff_mag_o | output | WIDTH | Combinational magnitude of A - B |
| diff_neg_o | output | 1 | Combinational sign; 1 means negative |
| out_valid_o | output | 1 | Registered valid, one cycle after `in_valid_i` |
| out_mag_o | output | WIDTH | Registered magnitude |
| out_neg_o | output | 1 | Registered sign |

## Verification
Equal operands are the case where the no-carry re-complement path and zero-sign suppression meet in the same cycle. The raw sum is all ones with no carry, so the sign rule alone would report negative zero. The bench provokes this case on every diagonal pair of the exhaustive sweep and at the directed vectors 0-0 and 128-128. It judges the case by requiring a zero magnitude with a positive sign, against an integer reference. A second overlap is the register stage capturing one vector while the combinational path already shows the next. The bench checks both outputs in the same cycle for every vector of the sweep.

// File: rtl/ocs_pkg.sv
package ocs_pkg;

    typedef enum logic {
        SIGN_POS = 1'b0,
        SIGN_NEG = 1'b1
    } sign_e;

    function automatic logic fa_sum(input logic x, input logic y, input logic c);
        return x ^ y ^ c;
    endfunction

    function automatic logic fa_carry(input logic x, input logic y, input logic c);
        return (x & y) | (c & (x ^ y));
    endfunction

    function automatic logic ha_sum(input logic x, input logic c);
        return x ^ c;
    endfunction

    function automatic logic ha_carry(input logic x, input logic c);
        return x & c;
    endfunction

endpackage

// File: rtl/ocs_invert_add.sv
module ocs_invert_add #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] minuend_i,
    input  logic [WIDTH-1:0] subtrahend_i,
    output logic [WIDTH-1:0] raw_sum_o,
    output logic             carry_o
);
    import ocs_pkg::*;

    logic [WIDTH-1:0] sub_inv;
    logic [WIDTH:0]   chain;

    assign sub_inv  = ~subtrahend_i;
    assign chain[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        assign raw_sum_o[i] = fa_sum(minuend_i[i], sub_inv[i], chain[i]);
        assign chain[i+1]   = fa_carry(minuend_i[i], sub_inv[i], chain[i]);
    end

    assign carry_o = chain[WIDTH];

endmodule

// File: rtl/ocs_correct.sv
module ocs_correct #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] raw_sum_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] mag_o,
    output ocs_pkg::sign_e   sign_o
);
    import ocs_pkg::*;

    logic [WIDTH-1:0] inc_sum;
    logic [WIDTH:0]   inc_chain;
    logic             raw_all_ones;

    // end-around carry: fold the carry back into bit 0
    assign inc_chain[0] = carry_i;
    for (genvar i = 0; i < WIDTH; i++) begin : g_inc
        assign inc_sum[i]     = ha_sum(raw_sum_i[i], inc_chain[i]);
        assign inc_chain[i+1] = ha_carry(raw_sum_i[i], inc_chain[i]);
    end

    assign raw_all_ones = &raw_sum_i;

    always_comb begin
        if (carry_i) begin
            mag_o  = inc_sum;
            sign_o = SIGN_POS;
        end else begin
            mag_o  = ~raw_sum_i;
            // all-ones raw sum is negative zero; report it as positive
            sign_o = raw_all_ones ? SIGN_POS : SIGN_NEG;
        end
    end

endmodule

// File: rtl/ocs_out_reg.sv
module ocs_out_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [WIDTH-1:0] mag_i,
    input  ocs_pkg::sign_e   sign_i,
    output logic             valid_o,
    output logic [WIDTH-1:0] mag_o,
    output ocs_pkg::sign_e   sign_o
);
    import ocs_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] mag;
        sign_e            sign;
    } result_t;

    result_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            held_q  <= '{mag: '0, sign: SIGN_POS};
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                held_q <= '{mag: mag_i, sign: sign_i};
            end
        end
    end

    assign mag_o  = held_q.mag;
    assign sign_o = held_q.sign;

endmodule

// File: rtl/ocs_subtractor.sv
module ocs_subtractor #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] diff_mag_o,
    output logic             diff_neg_o,
    output logic             out_valid_o,
    output logic [WIDTH-1:0] out_mag_o,
    output logic             out_neg_o
);
    import ocs_pkg::*;

    if (WIDTH < 2) begin : g_width_check
        $error("ocs_subtractor: WIDTH must be at least 2");
    end

    logic [WIDTH-1:0] raw_sum;
    logic             raw_carry;
    sign_e            comb_sign;
    sign_e            reg_sign;

    ocs_invert_add #(.WIDTH(WIDTH)) u_add (
        .minuend_i    (a_i),
        .subtrahend_i (b_i),
        .raw_sum_o    (raw_sum),
        .carry_o      (raw_carry)
    );

    ocs_correct #(.WIDTH(WIDTH)) u_fix (
        .raw_sum_i (raw_sum),
        .carry_i   (raw_carry),
        .mag_o     (diff_mag_o),
        .sign_o    (comb_sign)
    );

    ocs_out_reg #(.WIDTH(WIDTH)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .valid_i (in_valid_i),
        .mag_i   (diff_mag_o),
        .sign_i  (comb_sign),
        .valid_o (out_valid_o),
        .mag_o   (out_mag_o),
        .sign_o  (reg_sign)
    );

    assign diff_neg_o = (comb_sign == SIGN_NEG);
    assign out_neg_o  = (reg_sign == SIGN_NEG);

endmodule

// File: rtl/ocs_subtractor_chk.sv
module ocs_subtractor_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid_i,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [WIDTH-1:0] diff_mag_o,
    input logic             diff_neg_o,
    input logic             out_valid_o,
    input logic [WIDTH-1:0] out_mag_o,
    input logic             out_neg_o
);

    assert_pos_R1: assert property (@(posedge clk) disable iff (rst)
        (a_i > b_i) |-> (!diff_neg_o && diff_mag_o == WIDTH'(a_i - b_i)));

    assert_neg_R2: assert property (@(posedge clk) disable iff (rst)
        (a_i < b_i) |-> (diff_neg_o && diff_mag_o == WIDTH'(b_i - a_i)));

    assert_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (a_i == b_i) |-> (!diff_neg_o && diff_mag_o == '0));

    assert_no_neg_zero_R3: assert property (@(posedge clk) disable iff (rst)
        diff_neg_o |-> (diff_mag_o != '0));

    assert_valid_delay_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid_o == $past(in_valid_i)));

    assert_capture_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid_i)) |->
            (out_mag_o == $past(diff_mag_o) && out_neg_o == $past(diff_neg_o)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid_i)) |->
            ($stable(out_mag_o) && $stable(out_neg_o)));

endmodule

bind ocs_subtractor ocs_subtractor_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid_i  (in_valid_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .diff_mag_o  (diff_mag_o),
    .diff_neg_o  (diff_neg_o),
    .out_valid_o (out_valid_o),
    .out_mag_o   (out_mag_o),
    .out_neg_o   (out_neg_o)
);

// File: tb/ocs_subtractor_tb_top.sv
module ocs_subtractor_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int NVEC = 8;
    // {a, b, magnitude, negative}
    localparam logic [3*W:0] VECS [NVEC] = '{
        {8'd200, 8'd55,  8'd145, 1'b0},
        {8'd55,  8'd200, 8'd145, 1'b1},
        {8'd0,   8'd255, 8'd255, 1'b1},
        {8'd255, 8'd0,   8'd255, 1'b0},
        {8'd128, 8'd128, 8'd0,   1'b0},
        {8'd0,   8'd0,   8'd0,   1'b0},
        {8'd1,   8'd2,   8'd1,   1'b1},
        {8'd2,   8'd1,   8'd1,   1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vld = 1'b0;
    logic [W-1:0] a = '0, b = '0;
    logic [W-1:0] mag, omag;
    logic neg, ovld, oneg;

    logic [4:0] a5 = '0, b5 = '0, m5, om5;
    logic n5, ov5, on5;
    logic [3:0] a4 = '0, b4 = '0, m4, om4;
    logic n4, ov4, on4;
    logic [1:0] a2 = '0, b2 = '0, m2, om2;
    logic n2, ov2, on2;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ocs_subtractor #(.WIDTH(W)) dut_i (
        .clk(clk), .rst(rst), .in_valid_i(vld), .a_i(a), .b_i(b),
        .diff_mag_o(mag), .diff_neg_o(neg),
        .out_valid_o(ovld), .out_mag_o(omag), .out_neg_o(oneg));

    ocs_subtractor #(.WIDTH(5)) dut5_i (
        .clk(clk), .rst(rst), .in_valid_i(1'b0), .a_i(a5), .b_i(b5),
        .diff_mag_o(m5), .diff_neg_o(n5),
        .out_valid_o(ov5), .out_mag_o(om5), .out_neg_o(on5));

    ocs_subtractor #(.WIDTH(4)) dut4_i (
        .clk(clk), .rst(rst), .in_valid_i(1'b0), .a_i(a4), .b_i(b4),
        .diff_mag_o(m4), .diff_neg_o(n4),
        .out_valid_o(ov4), .out_mag_o(om4), .out_neg_o(on4));

    ocs_subtractor #(.WIDTH(2)) dut2_i (
        .clk(clk), .rst(rst), .in_valid_i(1'b0), .a_i(a2), .b_i(b2),
        .diff_mag_o(m2), .diff_neg_o(n2),
        .out_valid_o(ov2), .out_mag_o(om2), .out_neg_o(on2));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference result as {negative, magnitude}
    function automatic int ref_res(input int x, input int y);
        if (x >= y) return x - y;
        return 32'h100 | (y - x);
    endfunction

    initial begin
        int pexp;
        bit pvalid;
        // R8: reset state
        repeat (2) @(negedge clk);
        check(ovld == 1'b0, "R8 out_valid", int'(ovld), 0);
        check(omag == '0,   "R8 out_mag",   int'(omag), 0);
        check(oneg == 1'b0, "R8 out_neg",   int'(oneg), 0);
        rst = 1'b0;

        // table of directed vectors, R1 R2 R3
        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            a = VECS[k][3*W:2*W+1];
            b = VECS[k][2*W:W+1];
            #1;
            check(mag == VECS[k][W:1], "R1/R2/R3 table mag", int'(mag), int'(VECS[k][W:1]));
            check(neg == VECS[k][0],   "R1/R2/R3 table neg", int'(neg), int'(VECS[k][0]));
        end

        // exhaustive sweep with register stage checks (R7 R9 R10)
        pvalid = 1'b0;
        pexp = 0;
        vld = 1'b1;
        for (int x = 0; x < (1 << W); x++) begin
            for (int y = 0; y < (1 << W); y++) begin
                int e;
                @(negedge clk);
                if (pvalid) begin
                    check(ovld == 1'b1, "R9 out_valid", int'(ovld), 1);
                    check({23'd0, oneg, omag} == pexp, "R10 captured", int'({oneg, omag}), pexp);
                end
                a = W'(x);
                b = W'(y);
                #1;
                e = ref_res(x, y);
                if (x == y)
                    check({23'd0, neg, mag} == e, "R3 equal operands", int'({neg, mag}), e);
                else if (x > y)
                    check({23'd0, neg, mag} == e, "R1 positive", int'({neg, mag}), e);
                else
                    check({23'd0, neg, mag} == e, "R2 negative", int'({neg, mag}), e);
                pexp = e;
                pvalid = 1'b1;
            end
        end

        // R10 hold and R9 valid drop
        @(negedge clk);
        vld = 1'b0;
        a = 8'd10;
        b = 8'd3;
        #1;
        check({neg, mag} == 9'd7, "R7 same-cycle", int'({neg, mag}), 7);
        @(negedge clk);
        check({23'd0, oneg, omag} == pexp, "R10 captured last", int'({oneg, omag}), pexp);
        a = 8'd3;
        b = 8'd10;
        @(negedge clk);
        check(ovld == 1'b0, "R9 valid low", int'(ovld), 0);
        check({23'd0, oneg, omag} == pexp, "R10 hold", int'({oneg, omag}), pexp);

        // R4 and R5
        a5 = 5'b10000;
        b5 = 5'b11101;
        a4 = 4'd4;
        b4 = 4'd9;
        #1;
        check(m5 == 5'b01101, "R4 mag", int'(m5), 13);
        check(n5 == 1'b1,     "R4 neg", int'(n5), 1);
        check(m4 == 4'd5,     "R5 mag", int'(m4), 5);
        check(n4 == 1'b1,     "R5 neg", int'(n4), 1);

        // R6 single-bit rules in width 2
        for (int x = 0; x < 2; x++) begin
            for (int y = 0; y < 2; y++) begin
                int e;
                a2 = 2'(x);
                b2 = 2'(y);
                #1;
                e = (x >= y) ? (x - y) : 4'b0101;
                check({29'd0, n2, m2} == e, "R6 bit rule", int'({n2, m2}), e);
            end
        end

        // R8 reset again clears the stage
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check({ovld, oneg, omag} == '0, "R8 reset clear", int'({ovld, oneg, omag}), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule